// File: doc/BRIEF.md
# Digitizer Event Record Builder

This block turns one trigger into one event record for a multichannel waveform digitizer. Each channel delivers a free-running stream of ADC samples, one per clock. The samples are written continuously into a small circular buffer per channel. When a trigger arrives, the block stamps the event and keeps recording until the later of two programmable post-trigger delays has passed. It then freezes the buffers and streams the record out on a 32-bit valid/ready port.

A record holds two capture windows for every channel enabled in the mask. The first window has a fixed length. The second window's length is set by configuration. Each window has its own post-trigger delay in sample periods. Samples are widened to 16 bits and packed two per output word. Five trailer words close the record: the event ID, the 64-bit timestamp split into its upper and lower halves, the coarse acquisition time, and an all-ones end marker.

The timestamp is a free-running clock counter. The acquisition time counts coarse ticks, one every PRESCALE clocks; 1,000,000 at 100 MHz gives 10 ms. A trigger that arrives while a record is being built or emitted is still counted, but it produces no record.

Top module: `evb_record_builder`

## Requirements
- R1: While reset is applied and on the first cycle after it, out_valid and busy are 0.
- R2: A record lists the enabled channels in ascending index order; each channel's window 1 words are followed by its window 2 words, and the five trailer words come last.
- R3: With trigger sample index t, window w (length L, delay D) holds the samples of indices t+D-L+1 through t+D, in that order. Each sample is zero-extended to 16 bits, and two samples go in each word, with the earlier sample in bits 15:0.
- R4: Window 1 holds WIN1_LEN samples. Window 2 holds win2_len samples, an even number of at least 2. The mask, the lengths and both delays are taken on the trigger cycle.
- R5: The trailer words are, in order: event ID, timestamp bits 63:32, timestamp bits 31:0, acquisition ticks, and 32'hFFFFFFFF.
- R6: The timestamp equals the number of clock edges with rst_n high that come before the edge on which the trigger is sampled.
- R7: The acquisition tick field equals the timestamp divided by PRESCALE, rounded down.
- R8: Every trigger pulse increments the trigger count, including rejected ones. The event ID is the count including the accepting trigger, so the first trigger after reset gets ID 1.
- R9: busy rises on the edge after an accepted trigger. It falls only after the end marker has been transferred. A trigger while busy produces no record.
- R10: While out_valid is 1 and out_ready is 0, out_valid and out_data hold on the next cycle.
- R11: With an all-zero mask, the record consists of the trailer alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samples_in | input | NUM_CH*ADC_W | One sample per channel, channel 0 in the low bits |
| trig_in | input | 1 | Trigger pulse, aligned with the trigger sample |
| chan_en | input | NUM_CH | Channel enable mask |
| win2_len | input | clog2(BUF_DEPTH)+1 | Window 2 length in samples |
| win1_delay | input | clog2(BUF_DEPTH)+1 | Window 1 post-trigger delay in samples |
| win2_delay | input | clog2(BUF_DEPTH)+1 | Window 2 post-trigger delay in samples |
| out_data | output | 32 | Record word |
| out_valid | output | 1 | Record word available |
| out_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | A record is being built or emitted |

## Verification
The assertions take for granted that the configuration keeps each window inside the buffer: for both windows, max(delay) - D + L must not exceed BUF_DEPTH. They also assume window lengths are even and at least 2. A further assumption is that at least BUF_DEPTH samples have been written since reset or since the previous record ended before a trigger is accepted, so that the pre-trigger part of each window is fresh data. The stimulus meets these conditions: it keeps every configuration inside those limits and waits more than BUF_DEPTH idle cycles before each accepted trigger. It also fires a deliberate extra trigger during a busy period and throttles out_ready in several patterns to exercise backpressure.

// File: rtl/evb_pkg.sv
// Shared types and constants for the event record builder.
package evb_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_WIN1,
        PH_WIN2,
        PH_TRL
    } evb_phase_e;

    localparam int          OUT_W     = 32;
    localparam int          TRL_WORDS = 5;
    localparam logic [31:0] EOE_MARK  = 32'hFFFF_FFFF;
endpackage

// File: rtl/evb_timebase.sv
// Free-running timestamp and coarse acquisition-time counters.
// Assumes PRESCALE >= 2; ticks advance once every PRESCALE clocks.
module evb_timebase #(
    parameter int PRESCALE = 1000000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [63:0] ts_o,
    output logic [31:0] ticks_o
);
    localparam int PRE_W = $clog2(PRESCALE);

    logic [PRE_W-1:0] pre_q;

    // Timestamp counts every clock since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_o <= '0;
        else        ts_o <= ts_o + 64'd1;
    end

    // Prescaler produces the coarse tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            ticks_o <= '0;
        end else if (pre_q == PRE_W'(PRESCALE - 1)) begin
            pre_q   <= '0;
            ticks_o <= ticks_o + 32'd1;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R7
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ticks_o) |-> ($past(pre_q) == PRE_W'(PRESCALE - 1)) || $past(!rst_n));
endmodule

// File: rtl/evb_sample_ring.sv
// Per-channel circular sample buffers sharing one write pointer.
// Reads are combinational and return two adjacent samples, zero-extended to 16 bits.
// Assumes ADC_W <= 16 and BUF_DEPTH a power of two.
module evb_sample_ring #(
    parameter int NUM_CH    = 4,
    parameter int ADC_W     = 14,
    parameter int BUF_DEPTH = 1024,
    parameter int AW        = $clog2(BUF_DEPTH),
    parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [NUM_CH*ADC_W-1:0] samples_in,
    output logic [AW-1:0]           wr_ptr_o,
    input  logic [CH_W-1:0]         rd_ch,
    input  logic [AW-1:0]           rd_addr,
    output logic [15:0]             rd_lo,
    output logic [15:0]             rd_hi
);
    logic [ADC_W-1:0] lo_c [NUM_CH];
    logic [ADC_W-1:0] hi_c [NUM_CH];
    logic [AW-1:0]    rd_addr_nx;

    assign rd_addr_nx = rd_addr + AW'(1);

    // Write pointer advances with every stored sample.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr_o <= '0;
        else if (wr_en) wr_ptr_o <= wr_ptr_o + AW'(1);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [ADC_W-1:0] mem [BUF_DEPTH];

        // Store this channel's sample at the write pointer.
        always_ff @(posedge clk) begin
            if (wr_en) mem[wr_ptr_o] <= samples_in[c*ADC_W +: ADC_W];
        end

        assign lo_c[c] = mem[rd_addr];
        assign hi_c[c] = mem[rd_addr_nx];
    end

    // Select the channel being read and widen to 16 bits.
    always_comb begin
        rd_lo = 16'(lo_c[rd_ch]);
        rd_hi = 16'(hi_c[rd_ch]);
    end
endmodule

// File: rtl/evb_sequencer.sv
// Trigger handling, capture timing and record emission.
// Assumes window lengths are even and at least 2, and each window fits in the buffer.
module evb_sequencer
    import evb_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int WIN1_LEN = 1024,
    parameter int AW       = 10,
    parameter int LEN_W    = AW + 1,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [LEN_W-1:0]  win2_len,
    input  logic [LEN_W-1:0]  win1_delay,
    input  logic [LEN_W-1:0]  win2_delay,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [63:0]       ts,
    input  logic [31:0]       ticks,
    input  logic [15:0]       rd_lo,
    input  logic [15:0]       rd_hi,
    input  logic              out_ready,
    output logic              wr_en,
    output logic [CH_W-1:0]   rd_ch,
    output logic [AW-1:0]     rd_addr,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_valid,
    output logic              busy
);
    evb_phase_e        phase;
    logic [31:0]       trig_cnt, ev_id, ev_ticks;
    logic [63:0]       ev_ts;
    logic [NUM_CH-1:0] mask_q;
    logic [LEN_W-1:0]  len2_q, d1_q, d2_q, remain, idx, cur_len, dmax;
    logic [AW-1:0]     trig_ptr, start1, start2;
    logic [CH_W-1:0]   cur_ch, first_ch, next_ch;
    logic              has_next, fire, win_end;
    logic [2:0]        tw_idx;

    // Window start addresses and channel scan results.
    always_comb begin
        dmax     = (win1_delay > win2_delay) ? win1_delay : win2_delay;
        start1   = trig_ptr + AW'(d1_q) - AW'(WIN1_LEN) + AW'(1);
        start2   = trig_ptr + AW'(d2_q) - AW'(len2_q) + AW'(1);
        cur_len  = (phase == PH_WIN1) ? LEN_W'(WIN1_LEN) : len2_q;
        first_ch = '0;
        next_ch  = '0;
        has_next = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask_q[i]) first_ch = CH_W'(i);
            if (mask_q[i] && i > int'(cur_ch)) begin
                has_next = 1'b1;
                next_ch  = CH_W'(i);
            end
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign out_valid = (phase == PH_WIN1) || (phase == PH_WIN2) || (phase == PH_TRL);
    assign fire      = out_valid && out_ready;
    assign win_end   = ({1'b0, idx} + (LEN_W+1)'(2)) >= {1'b0, cur_len};
    assign wr_en     = (phase == PH_IDLE) || (phase == PH_WAIT && remain != '0);
    assign rd_ch     = cur_ch;
    assign rd_addr   = ((phase == PH_WIN2) ? start2 : start1) + idx[AW-1:0];

    // Output word selection: packed samples or trailer fields.
    always_comb begin
        if (phase == PH_TRL) begin
            case (tw_idx)
                3'd0:    out_data = ev_id;
                3'd1:    out_data = ev_ts[63:32];
                3'd2:    out_data = ev_ts[31:0];
                3'd3:    out_data = ev_ticks;
                default: out_data = EOE_MARK;
            endcase
        end else begin
            out_data = {rd_hi, rd_lo};
        end
    end

    // Trigger counter counts every trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       trig_cnt <= '0;
        else if (trig_in) trig_cnt <= trig_cnt + 32'd1;
    end

    // Record state machine: accept, wait out delays, emit windows and trailer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            ev_id    <= '0;
            ev_ts    <= '0;
            ev_ticks <= '0;
            mask_q   <= '0;
            len2_q   <= '0;
            d1_q     <= '0;
            d2_q     <= '0;
            remain   <= '0;
            trig_ptr <= '0;
            cur_ch   <= '0;
            idx      <= '0;
            tw_idx   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (trig_in) begin
                    ev_id    <= trig_cnt + 32'd1;
                    ev_ts    <= ts;
                    ev_ticks <= ticks;
                    mask_q   <= chan_en;
                    len2_q   <= win2_len;
                    d1_q     <= win1_delay;
                    d2_q     <= win2_delay;
                    trig_ptr <= wr_ptr;
                    remain   <= dmax;
                    phase    <= PH_WAIT;
                end
                PH_WAIT: begin
                    idx    <= '0;
                    tw_idx <= '0;
                    if (remain != '0) remain <= remain - LEN_W'(1);
                    else if (|mask_q) begin
                        cur_ch <= first_ch;
                        phase  <= PH_WIN1;
                    end else phase <= PH_TRL;
                end
                PH_WIN1: if (fire) begin
                    if (win_end) begin
                        idx   <= '0;
                        phase <= PH_WIN2;
                    end else idx <= idx + LEN_W'(2);
                end
                PH_WIN2: if (fire) begin
                    if (win_end) begin
                        idx <= '0;
                        if (has_next) begin
                            cur_ch <= next_ch;
                            phase  <= PH_WIN1;
                        end else phase <= PH_TRL;
                    end else idx <= idx + LEN_W'(2);
                end
                PH_TRL: if (fire) begin
                    if (tw_idx == 3'(TRL_WORDS - 1)) phase <= PH_IDLE;
                    else tw_idx <= tw_idx + 3'd1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fire && out_data == EOE_MARK));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_in && !busy |=> busy);

    // R3
    frozen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !wr_en);
endmodule

// File: rtl/evb_record_builder.sv
// Top level: sample ring, timebase and record sequencer.
// Assumes a power-of-two BUF_DEPTH, WIN1_LEN even and not above BUF_DEPTH.
module evb_record_builder #(
    parameter int NUM_CH    = 4,
    parameter int ADC_W     = 14,
    parameter int WIN1_LEN  = 1024,
    parameter int BUF_DEPTH = 1024,
    parameter int PRESCALE  = 1000000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH*ADC_W-1:0]       samples_in,
    input  logic                          trig_in,
    input  logic [NUM_CH-1:0]             chan_en,
    input  logic [$clog2(BUF_DEPTH):0]    win2_len,
    input  logic [$clog2(BUF_DEPTH):0]    win1_delay,
    input  logic [$clog2(BUF_DEPTH):0]    win2_delay,
    output logic [31:0]                   out_data,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic                          busy
);
    localparam int AW    = $clog2(BUF_DEPTH);
    localparam int LEN_W = AW + 1;
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic            wr_en;
    logic [AW-1:0]   wr_ptr, rd_addr;
    logic [CH_W-1:0] rd_ch;
    logic [15:0]     rd_lo, rd_hi;
    logic [63:0]     ts;
    logic [31:0]     ticks;

    evb_timebase #(.PRESCALE(PRESCALE)) u_time (
        .clk(clk), .rst_n(rst_n), .ts_o(ts), .ticks_o(ticks)
    );

    evb_sample_ring #(
        .NUM_CH(NUM_CH), .ADC_W(ADC_W), .BUF_DEPTH(BUF_DEPTH), .AW(AW), .CH_W(CH_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .samples_in(samples_in),
        .wr_ptr_o(wr_ptr), .rd_ch(rd_ch), .rd_addr(rd_addr),
        .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    evb_sequencer #(
        .NUM_CH(NUM_CH), .WIN1_LEN(WIN1_LEN), .AW(AW), .LEN_W(LEN_W), .CH_W(CH_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .chan_en(chan_en),
        .win2_len(win2_len), .win1_delay(win1_delay), .win2_delay(win2_delay),
        .wr_ptr(wr_ptr), .ts(ts), .ticks(ticks), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .out_ready(out_ready), .wr_en(wr_en), .rd_ch(rd_ch), .rd_addr(rd_addr),
        .out_data(out_data), .out_valid(out_valid), .busy(busy)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !out_valid && !busy);
endmodule

// File: tb/evb_record_builder_test.sv
// Scoreboard bench: the driver queues expected words, the monitor compares accepted words.
module evb_record_builder_test;
    localparam int NCH   = 3;
    localparam int AW_T  = 14;
    localparam int L1    = 16;
    localparam int DEP   = 64;
    localparam int PRE   = 50;
    localparam int LW    = $clog2(DEP) + 1;

    logic                  clk = 0;
    logic                  rst_n = 0;
    logic [NCH*AW_T-1:0]   samples_in = '0;
    logic                  trig_in = 0;
    logic [NCH-1:0]        chan_en = '0;
    logic [LW-1:0]         win2_len = '0, win1_delay = '0, win2_delay = '0;
    logic [31:0]           out_data;
    logic                  out_valid, busy;
    logic                  out_ready = 1;

    int          n_checks = 0, n_fail = 0;
    longint      bc = 0;
    int          trig_total = 0;
    int          bp_mode = 0;
    int          rdy_cnt = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    evb_record_builder #(
        .NUM_CH(NCH), .ADC_W(AW_T), .WIN1_LEN(L1), .BUF_DEPTH(DEP), .PRESCALE(PRE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .samples_in(samples_in), .trig_in(trig_in),
        .chan_en(chan_en), .win2_len(win2_len), .win1_delay(win1_delay),
        .win2_delay(win2_delay), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .busy(busy)
    );

    always #4 clk = ~clk;

    // Bench cycle count: edges with rst_n high (timestamp reference, R6).
    always @(posedge clk) begin
        if (!rst_n) bc <= 0;
        else        bc <= bc + 1;
    end

    function automatic logic [15:0] smp(longint n, int c);
        return 16'((n * 37 + c * 5003 + 11) & 32'h3FFF);
    endfunction

    // Drive each channel's sample for the coming edge.
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) samples_in[c*AW_T +: AW_T] <= AW_T'(smp(bc, c));
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: set ready pattern, then compare any word that will transfer.
    always @(negedge clk) begin
        rdy_cnt++;
        case (bp_mode)
            1:       out_ready = (rdy_cnt % 3) != 0;
            2:       out_ready = (rdy_cnt % 5) == 0;
            default: out_ready = 1'b1;
        endcase
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) check(0, "R9 unexpected word", out_data, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data === e, t, out_data, e);
            end
        end
    end

    task automatic push(input logic [31:0] w, input string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    // Driver: fire one accepted trigger and queue its record (R2 R3 R4 R5 R6 R7 R8).
    task automatic run_event(input logic [NCH-1:0] m, input int len2, input int d1, input int d2,
                             input bit extra_trig);
        longint t;
        @(negedge clk);
        chan_en = m; win2_len = LW'(len2); win1_delay = LW'(d1); win2_delay = LW'(d2);
        trig_in = 1;
        t = bc;
        trig_total++;
        for (int c = 0; c < NCH; c++) begin
            if (m[c]) begin
                for (int k = 0; k < L1; k += 2)
                    push({smp(t + d1 - L1 + 1 + k + 1, c), smp(t + d1 - L1 + 1 + k, c)}, "R3 window1 word");
                for (int k = 0; k < len2; k += 2)
                    push({smp(t + d2 - len2 + 1 + k + 1, c), smp(t + d2 - len2 + 1 + k, c)}, "R4 window2 word");
            end
        end
        push(32'(trig_total), "R8 event id");
        push(32'(t >> 32), "R5 timestamp high");
        push(32'(t), "R6 timestamp low");
        push(32'(t / PRE), "R7 acquisition ticks");
        push(32'hFFFF_FFFF, "R5 end marker");
        @(negedge clk);
        trig_in = 0;
        chan_en = '0; win2_len = '0; win1_delay = '0; win2_delay = '0;
        check(busy === 1'b1, "R9 busy after trigger", 32'(busy), 32'h1);
        if (extra_trig) begin
            repeat (3) @(negedge clk);
            trig_in = 1;
            trig_total++;
            @(negedge clk);
            trig_in = 0;
        end
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, "R2 record complete at busy fall", 32'(exp_q.size()), 32'h0);
        check(out_valid === 1'b0, "R9 idle after record", 32'(out_valid), 32'h0);
        repeat (DEP + 20) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=busy expected=idle");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(out_valid === 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'h0);
        check(busy === 1'b0, "R1 busy in reset", 32'(busy), 32'h0);
        rst_n = 1;
        @(negedge clk);
        check(out_valid === 1'b0 && busy === 1'b0, "R1 idle after reset", {out_valid, busy}, 32'h0);
        repeat (DEP + 10) @(negedge clk);

        bp_mode = 1;
        run_event(3'b101, 8, 5, 3, 0);
        bp_mode = 0;
        run_event(3'b111, 4, 0, 10, 1);          // R8: rejected trigger still counted
        run_event(3'b000, 8, 2, 2, 0);           // R11: trailer only
        bp_mode = 2;
        run_event(3'b010, 20, 20, 2, 0);         // R10 heavy backpressure
        bp_mode = 0;
        run_event(3'b100, 2, 15, 0, 0);

        check(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule